// File: doc/BRIEF.md
# Match Timer with Interrupt

This block is an up-counting timer with a single compare channel, controlled through a small register port. A programmable prescaler sets how often the main counter advances. The counter is compared against a match value. A compare hit can raise an interrupt flag, reload the counter with zero, and halt the timer, and each of these three actions is enabled separately. From the same counter, software therefore gets a free-running timebase, a periodic tick or a one-shot delay.

Software starts the timer by setting the run bit. A separate clear bit holds the counter and the prescale counter at zero for as long as it stays set. Software acknowledges an interrupt by writing a one to the flag bit. Every register sits at a fixed byte offset. Reads return data one clock after the address is presented.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Control register (offset 0x04): bit 0 is run and bit 1 is clear. While clear is set, the counter and the prescale counter stay at zero, and clear overrides both run and a counter write. With run at 0 the counter holds its value.
- R3: With prescale value P (offset 0x0C), the counter (offset 0x08) advances by one every P+1 clocks in which the timer runs. With P = 0 it advances every clock.
- R4: Match-action register (offset 0x14, 3 bits read back): when bit 0 is set, the flag (offset 0x00, bit 0) is set in the clock where the counter advances into the match value (offset 0x18). `irq` equals the flag. With bit 0 clear the flag never sets.
- R5: Match-action bit 1: at the first advance after the counter equals the match value, the counter goes to zero instead of incrementing. A match value N therefore gives a period of N+1 counts.
- R6: Match-action bit 2: at that same advance, the run bit is cleared and the timer stops. The counter becomes zero if bit 1 is also set, and otherwise it stays at the match value.
- R7: Writing 1 to flag bit 0 clears the flag, and writing 0 leaves it unchanged. If a new match and a clear fall in the same clock, the flag stays set.
- R8: With no match action enabled the counter wraps from 0xFFFFFFFF to 0. The counter can be written while the clear bit is low.
- R9: Count-mode register (offset 0x70, 2 bits): only value 0 lets the counter advance. Any other value freezes it.
- R10: Reads of unmapped offsets return zero, and writes to them change no register.
- R11: `rd_data` presents the register selected by `addr` one clock after `addr` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW (8) | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW (32) | Write data |
| rd_data | output | DW (32) | Registered read data |
| irq | output | 1 | Level interrupt, high while the flag is set |

## Verification
The counter is exercised with prescale values of zero and three. This separates per-clock advance from divided advance. It is run under four compare-action settings: none, reset only, stop only, and reset with stop. The final counter value and the run bit distinguish wrapping, periodic reload, halting at the match value and halting at zero. A flag clear is timed to land exactly on a compare hit, which shows that a new hit takes priority over the acknowledge. Writes and reads at unmapped offsets, and a non-zero count mode, show that these leave the state untouched and the counter frozen.

// File: rtl/match_timer.sv
module match_timer #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int MW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          irq
);
  localparam logic [AW-1:0] OFF_FLAG = AW'(8'h00);
  localparam logic [AW-1:0] OFF_CTRL = AW'(8'h04);
  localparam logic [AW-1:0] OFF_CNT  = AW'(8'h08);
  localparam logic [AW-1:0] OFF_PRE  = AW'(8'h0C);
  localparam logic [AW-1:0] OFF_ACT  = AW'(8'h14);
  localparam logic [AW-1:0] OFF_CMP  = AW'(8'h18);
  localparam logic [AW-1:0] OFF_MODE = AW'(8'h70);

  logic          run, hold, flag;
  logic [DW-1:0] count, pre, pcnt, cmp;
  logic [2:0]    act;
  logic [MW-1:0] mode;

  wire tick     = run & ~hold & (mode == '0);
  wire step     = tick & (pcnt >= pre);
  wire at_cmp   = (count == cmp);
  wire do_rst   = step & at_cmp & act[1];
  wire do_stop  = step & at_cmp & act[2];
  wire [DW-1:0] cnt_nxt = do_rst ? '0 : (do_stop ? count : count + 1'b1);
  wire hit      = step & act[0] & ~do_stop & (cnt_nxt == cmp);
  wire wsel_flag = wr_en & (addr == OFF_FLAG);
  wire wsel_ctrl = wr_en & (addr == OFF_CTRL);
  wire wsel_cnt  = wr_en & (addr == OFF_CNT);

  assign irq = flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      hold <= 1'b0;
    end else if (wsel_ctrl) begin
      run  <= wr_data[0];
      hold <= wr_data[1];
    end else if (do_stop) begin
      run  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      pcnt  <= '0;
    end else if (hold) begin
      count <= '0;
      pcnt  <= '0;
    end else begin
      if (wsel_cnt)  count <= wr_data;
      else if (step) count <= cnt_nxt;
      if (tick)      pcnt  <= step ? '0 : pcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= hit | (flag & ~(wsel_flag & wr_data[0]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre  <= '0;
      act  <= '0;
      cmp  <= '0;
      mode <= '0;
    end else if (wr_en) begin
      case (addr)
        OFF_PRE:  pre  <= wr_data;
        OFF_ACT:  act  <= wr_data[2:0];
        OFF_CMP:  cmp  <= wr_data;
        OFF_MODE: mode <= wr_data[MW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else begin
      case (addr)
        OFF_FLAG: rd_data <= DW'(flag);
        OFF_CTRL: rd_data <= DW'({hold, run});
        OFF_CNT:  rd_data <= count;
        OFF_PRE:  rd_data <= pre;
        OFF_ACT:  rd_data <= DW'(act);
        OFF_CMP:  rd_data <= cmp;
        OFF_MODE: rd_data <= DW'(mode);
        default:  rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] rd_data,
  input logic          irq,
  input logic          run,
  input logic          hold,
  input logic          flag,
  input logic [DW-1:0] count,
  input logic [2:0]    act
);
  wire wr_cnt   = wr_en && addr == AW'(8'h08);
  wire wr_ctrl  = wr_en && addr == AW'(8'h04);
  wire clr_flag = wr_en && addr == AW'(8'h00) && wr_data[0];
  wire unmapped = !(addr inside {AW'(8'h00), AW'(8'h04), AW'(8'h08), AW'(8'h0C),
                                 AW'(8'h14), AW'(8'h18), AW'(8'h70)});

  a_r2_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> count == '0);

  a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !hold && !wr_cnt) |=> $stable(count));

  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && !hold) |=> (count == $past(count) || count == $past(count) + 1'b1 || count == '0));

  a_r4_flag_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !act[0]) |=> !flag);

  a_r4_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> irq);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_flag) |=> flag);

  a_r6_stop_source: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wr_ctrl && !act[2]) |=> run);

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |=> rd_data == '0);
endmodule

bind match_timer match_timer_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .irq(irq), .run(run), .hold(hold), .flag(flag),
  .count(count), .act(act)
);

// File: tb/test_match_timer.sv
`timescale 1ns/1ps
module test_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  always #2.5 clk = ~clk;

  match_timer i_match_timer (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_req = 1'b0;
  logic        rd_pend = 1'b0;

  always @(posedge clk) rd_pend <= rd_req;

  always @(negedge clk) begin
    if (rd_pend) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL %s: read result with no expected item", "R11");
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    addr = a; rd_req = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input logic act_v, input logic exp_v, input string t);
    n_cmp++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", t, act_v, exp_v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(irq, 1'b0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h00, 0, "R1"); rd(8'h04, 0, "R1"); rd(8'h08, 0, "R1"); rd(8'h0C, 0, "R1");
    rd(8'h14, 0, "R1"); rd(8'h18, 0, "R1"); rd(8'h70, 0, "R1");
    chk(irq, 1'b0, "R1");

    // R3 prescale 0 then R2 freeze
    wr(8'h04, 2); wr(8'h04, 1); idle(9); wr(8'h04, 0);
    rd(8'h08, 10, "R3"); idle(5); rd(8'h08, 10, "R2"); rd(8'h04, 0, "R2");

    // R3 prescale 3
    wr(8'h0C, 3); wr(8'h04, 2); wr(8'h04, 1); idle(12); wr(8'h04, 0);
    rd(8'h08, 3, "R3"); rd(8'h0C, 3, "R3");

    // R2 clear overrides run and counter write
    wr(8'h04, 3); idle(4); wr(8'h08, 32'h55); rd(8'h08, 0, "R2"); rd(8'h04, 3, "R2");
    wr(8'h04, 0);

    // R5 periodic with match 4
    wr(8'h0C, 0); wr(8'h18, 4); wr(8'h14, 3); wr(8'h04, 2); wr(8'h04, 1);
    idle(11); wr(8'h04, 0);
    rd(8'h08, 2, "R5"); rd(8'h00, 1, "R4"); chk(irq, 1'b1, "R4");

    // R7 write-one-to-clear
    wr(8'h00, 0); rd(8'h00, 1, "R7");
    wr(8'h00, 1); rd(8'h00, 0, "R7"); chk(irq, 1'b0, "R7");

    // R6 one-shot with reset
    wr(8'h18, 3); wr(8'h14, 7); wr(8'h04, 2); wr(8'h04, 1); idle(9);
    rd(8'h08, 0, "R6"); rd(8'h04, 0, "R6"); rd(8'h00, 1, "R6");
    wr(8'h00, 1);

    // R6 stop without reset
    wr(8'h14, 5); wr(8'h04, 2); wr(8'h04, 1); idle(9);
    rd(8'h08, 3, "R6"); rd(8'h04, 0, "R6"); rd(8'h00, 1, "R4");
    wr(8'h00, 1);

    // R7 new match wins over same-cycle clear
    wr(8'h18, 2); wr(8'h14, 3); wr(8'h04, 2); wr(8'h04, 1); idle(4);
    wr(8'h00, 1); wr(8'h04, 0);
    rd(8'h00, 1, "R7"); wr(8'h00, 1); rd(8'h00, 0, "R7");

    // R8 wrap, no actions
    wr(8'h14, 0); wr(8'h04, 2); wr(8'h04, 0); wr(8'h08, 32'hFFFF_FFFD);
    rd(8'h08, 32'hFFFF_FFFD, "R8");
    wr(8'h04, 1); idle(4); wr(8'h04, 0);
    rd(8'h08, 2, "R8"); rd(8'h00, 0, "R4"); chk(irq, 1'b0, "R4");

    // R9 count mode
    wr(8'h70, 32'hFF); rd(8'h70, 3, "R9");
    wr(8'h04, 2); wr(8'h04, 1); idle(5); wr(8'h04, 0);
    rd(8'h08, 0, "R9"); wr(8'h70, 0);

    // R10 unmapped offsets
    wr(8'h0C, 5); wr(8'h10, 32'hDEAD); wr(8'h74, 32'hBEEF);
    rd(8'h10, 0, "R10"); rd(8'h74, 0, "R10"); rd(8'h0C, 5, "R10");
    rd(8'h18, 2, "R10"); rd(8'h08, 0, "R10");
    wr(8'h14, 32'hFF); rd(8'h14, 7, "R4");

    // R11 back-to-back reads of different registers
    rd(8'h0C, 5, "R11"); rd(8'h18, 2, "R11"); rd(8'h0C, 5, "R11");

    idle(3);
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R11: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule